// File: doc/BRIEF.md
# Ternary Rotating-Pointer Cell Selector

This block sits between a digital delta-sigma modulator and a segmented DAC built from eight unit cells. On every strobed sample it takes a signed level and drives each cell to +1, 0 or -1, so that the cell values add up to the requested level. It chooses which cells fire by rotating selection, which spreads cell mismatch over time and pushes the resulting error out of the signal band.

The block keeps up to four independent rotation pointers and uses them in turn, one per sample. One pointer shapes mismatch for low-pass or high-pass bands. Two or four pointers place the mismatch notch for band-pass operation. Two kinds of selection are available. In rotate mode, cells are taken upward from the pointer and wrap around the array. In sweep mode, each pointer reverses its direction of travel after every use. A mode input limits the cells to +1/0 for binary operation.

Top module: `dwa_tern_sel`

## Requirements
- R1: While `rst` is high at a clock edge, the next state has `out_valid` = 0, all cell codes zero, every pointer at cell 0, every sweep direction forward and the turn index at 0.
- R2: `out_valid` is high exactly one cycle after each `in_valid` sample. `cell_code` changes only in that cycle and holds its value otherwise.
- R3: Cell i occupies `cell_code[2i+1:2i]`, with 00 for zero, 01 for +1 and 11 for -1. The code 10 never appears. The number of nonzero cells equals the clamped magnitude of the level, and all nonzero cells carry the level's sign.
- R4: In rotate mode (`sweep_mode` = 0), a sample of magnitude m drives cells p, p+1, ..., p+m-1 (mod 8), where p is the active pointer. The pointer then becomes p+m (mod 8).
- R5: In sweep mode (`sweep_mode` = 1), a pointer travelling forward behaves as in R4 and then turns backward. A pointer travelling backward drives cells p-1, p-2, ..., p-m (mod 8), becomes p-m (mod 8) and then turns forward.
- R6: `ptr_cfg` selects the pointer count: 0 gives 1, 1 gives 2, and 2 or 3 gives 4. The k-th strobed sample after reset uses pointer k mod count, and every other pointer is left untouched.
- R7: A zero level drives every cell to zero and leaves the pointer and its direction unchanged. It still counts as a turn for R6.
- R8: In binary mode (`tern_mode` = 0), positive levels drive +1 cells as in R4/R5. A negative level is treated as zero, as in R7.
- R9: Levels with a magnitude above 8 (from -16 to -9 and from 9 to 15) are clamped to magnitude 8.
- R10: Without `in_valid`, no pointer, direction or turn index changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_level | input | 5 | Signed two's-complement requested level |
| tern_mode | input | 1 | 1 = ternary cells, 0 = binary cells |
| sweep_mode | input | 1 | 0 = rotate selection, 1 = back-and-forth selection |
| ptr_cfg | input | 2 | Pointer count select (R6) |
| out_valid | output | 1 | Registered strobe for `cell_code` |
| cell_code | output | 16 | Two-bit code per cell, registered |

## Verification
The bench drives runs that carry a pointer past cell 7. A design that forgets the modulo would drop cells or select cells outside the array. It checks a sweep-mode sequence in which a backward step crosses cell 0, which catches a reversed or missing direction toggle. Interleaved samples under two and four pointers expose a turn index that fails to advance, or that moves the wrong pointer. Zero levels, negative levels in binary mode and out-of-range levels check that pointers stay put and that magnitudes clamp. A design that got these wrong would shift every later selection away from the reference sequence.

// File: rtl/dwa_pkg.sv
package dwa_pkg;
  localparam logic [1:0] CODE_ZERO = 2'b00;
  localparam logic [1:0] CODE_POS  = 2'b01;
  localparam logic [1:0] CODE_NEG  = 2'b11;
endpackage

// File: rtl/dwa_level_decode.sv
module dwa_level_decode #(
  parameter int NUM_CELLS = 8,
  parameter int LVL_W     = 5,
  localparam int PW = $clog2(NUM_CELLS),
  localparam int MW = PW + 1
) (
  input  logic signed [LVL_W-1:0] level,
  input  logic                    tern_mode,
  output logic [MW-1:0]           mag,
  output logic                    neg
);
  logic             is_neg;
  logic [LVL_W-1:0] abs_v;

  always_comb begin
    is_neg = level[LVL_W-1];
    abs_v  = is_neg ? (~level + 1'b1) : level;
    neg    = is_neg & tern_mode;
    if (is_neg && !tern_mode)
      mag = '0;
    else if (abs_v > LVL_W'(NUM_CELLS))
      mag = MW'(NUM_CELLS);
    else
      mag = abs_v[MW-1:0];
  end
endmodule

// File: rtl/dwa_ptr_bank.sv
module dwa_ptr_bank #(
  parameter int NUM_CELLS = 8,
  parameter int MAX_PTRS  = 4,
  localparam int PW = $clog2(NUM_CELLS),
  localparam int MW = PW + 1,
  localparam int IW = $clog2(MAX_PTRS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          sweep_mode,
  input  logic [1:0]    ptr_cfg,
  input  logic [MW-1:0] mag,
  output logic [PW-1:0] start_pos
);
  logic [PW-1:0] ptr_q [MAX_PTRS];
  logic          dir_q [MAX_PTRS];
  logic [IW-1:0] turn_q;
  logic [IW-1:0] idx_mask;
  logic [IW-1:0] act;
  logic [PW-1:0] cur_p;
  logic          backward;
  logic [PW-1:0] step;
  logic [PW-1:0] next_p;
  logic          flip;

  always_comb begin
    idx_mask  = IW'((32'd1 << ptr_cfg) - 32'd1) & IW'(MAX_PTRS - 1);
    act       = turn_q & idx_mask;
    cur_p     = ptr_q[act];
    backward  = sweep_mode & dir_q[act];
    step      = mag[PW-1:0];
    next_p    = backward ? (cur_p - step) : (cur_p + step);
    start_pos = backward ? next_p : cur_p;
    flip      = sweep_mode & (mag != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) turn_q <= '0;
    else if (adv) turn_q <= (turn_q + 1'b1) & idx_mask;
  end

  for (genvar g = 0; g < MAX_PTRS; g++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (rst) begin
        ptr_q[g] <= '0;
        dir_q[g] <= 1'b0;
      end else if (adv && act == IW'(g)) begin
        ptr_q[g] <= next_p;
        if (flip) dir_q[g] <= ~dir_q[g];
      end
    end
  end
endmodule

// File: rtl/dwa_cell_map.sv
module dwa_cell_map #(
  parameter int NUM_CELLS = 8,
  localparam int PW = $clog2(NUM_CELLS),
  localparam int MW = PW + 1
) (
  input  logic [PW-1:0]            start_pos,
  input  logic [MW-1:0]            mag,
  input  logic                     neg,
  output logic [2*NUM_CELLS-1:0]   codes
);
  import dwa_pkg::*;

  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
    localparam logic [PW-1:0] CIDX = PW'(c);
    logic [PW-1:0] offs;
    logic          on;
    always_comb begin
      offs = CIDX - start_pos;
      on   = {1'b0, offs} < mag;
      codes[2*c+1:2*c] = on ? (neg ? CODE_NEG : CODE_POS) : CODE_ZERO;
    end
  end
endmodule

// File: rtl/dwa_tern_sel.sv
module dwa_tern_sel #(
  parameter int NUM_CELLS = 8,
  parameter int MAX_PTRS  = 4,
  parameter int LVL_W     = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic signed [LVL_W-1:0] in_level,
  input  logic                   tern_mode,
  input  logic                   sweep_mode,
  input  logic [1:0]             ptr_cfg,
  output logic                   out_valid,
  output logic [2*NUM_CELLS-1:0] cell_code
);
  localparam int PW = $clog2(NUM_CELLS);
  localparam int MW = PW + 1;

  logic [MW-1:0]          mag_w;
  logic                   neg_w;
  logic [PW-1:0]          start_w;
  logic [2*NUM_CELLS-1:0] codes_w;

  dwa_level_decode #(.NUM_CELLS(NUM_CELLS), .LVL_W(LVL_W)) dec_i (
    .level(in_level), .tern_mode(tern_mode), .mag(mag_w), .neg(neg_w)
  );

  dwa_ptr_bank #(.NUM_CELLS(NUM_CELLS), .MAX_PTRS(MAX_PTRS)) bank_i (
    .clk(clk), .rst(rst), .adv(in_valid), .sweep_mode(sweep_mode),
    .ptr_cfg(ptr_cfg), .mag(mag_w), .start_pos(start_w)
  );

  dwa_cell_map #(.NUM_CELLS(NUM_CELLS)) map_i (
    .start_pos(start_w), .mag(mag_w), .neg(neg_w), .codes(codes_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      cell_code <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) cell_code <= codes_w;
    end
  end
endmodule

// File: rtl/dwa_tern_sel_chk.sv
module dwa_tern_sel_chk #(
  parameter int NUM_CELLS = 8,
  parameter int LVL_W     = 5
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic signed [LVL_W-1:0] in_level,
  input logic                   tern_mode,
  input logic                   out_valid,
  input logic [2*NUM_CELLS-1:0] cell_code
);
  int   n_pos, n_neg, n_bad;
  int   want;
  always_comb begin
    n_pos = 0; n_neg = 0; n_bad = 0;
    for (int i = 0; i < NUM_CELLS; i++) begin
      if (cell_code[2*i +: 2] == 2'b01) n_pos++;
      if (cell_code[2*i +: 2] == 2'b11) n_neg++;
      if (cell_code[2*i +: 2] == 2'b10) n_bad++;
    end
    if (in_level < 0) want = tern_mode ? -int'(in_level) : 0;
    else              want = int'(in_level);
    if (want > NUM_CELLS) want = NUM_CELLS;
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r2_hold_codes: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(cell_code));
  a_r3_legal_codes: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (n_bad == 0));
  a_r3_one_sign: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (n_pos == 0 || n_neg == 0));
  a_r3_cell_count: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (n_pos + n_neg == $past(want)));
  a_r8_binary_no_minus: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !tern_mode) |=> (n_neg == 0));
endmodule

bind dwa_tern_sel dwa_tern_sel_chk #(.NUM_CELLS(NUM_CELLS), .LVL_W(LVL_W)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_level(in_level),
  .tern_mode(tern_mode), .out_valid(out_valid), .cell_code(cell_code)
);

// File: tb/dwa_tern_sel_tb_top.sv
module dwa_tern_sel_tb_top;
  logic              clk = 1'b0;
  logic              rst;
  logic              in_valid;
  logic signed [4:0] in_level;
  logic              tern_mode;
  logic              sweep_mode;
  logic [1:0]        ptr_cfg;
  logic              out_valid;
  logic [15:0]       cell_code;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  int m_ptr [4];
  bit m_dir [4];
  int m_idx;

  always #5 clk = ~clk;

  dwa_tern_sel dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_level(in_level),
    .tern_mode(tern_mode), .sweep_mode(sweep_mode), .ptr_cfg(ptr_cfg),
    .out_valid(out_valid), .cell_code(cell_code)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin m_ptr[i] = 0; m_dir[i] = 0; end
    m_idx = 0;
  endtask

  function automatic logic [15:0] model_step(int lvl);
    int mag, n, a, p, st;
    bit neg, back;
    logic [15:0] e;
    e = '0;
    neg = (lvl < 0) && tern_mode;
    mag = (lvl < 0) ? (tern_mode ? -lvl : 0) : lvl;
    if (mag > 8) mag = 8;
    n = (ptr_cfg == 0) ? 1 : (ptr_cfg == 1) ? 2 : 4;
    a = m_idx % n;
    p = m_ptr[a];
    back = sweep_mode && m_dir[a];
    st = back ? ((p - mag + 16) % 8) : p;
    for (int c = 0; c < 8; c++)
      if (((c - st + 8) % 8) < mag) e[2*c +: 2] = neg ? 2'b11 : 2'b01;
    m_ptr[a] = back ? st : ((p + mag) % 8);
    if (sweep_mode && mag != 0) m_dir[a] = !m_dir[a];
    m_idx = (m_idx + 1) % n;
    return e;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; in_level = '0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  // drive one sample, then check the registered result one edge later
  task automatic send(int lvl, string req);
    logic [15:0] e;
    in_level = 5'(lvl);
    in_valid = 1'b1;
    e = model_step(lvl);
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, 32'(out_valid), 32'd1);
    check({req, " codes"}, 32'(cell_code), 32'(e));
  endtask

  task automatic t_reset();
    rst = 1'b1; in_valid = 1'b0; in_level = '0;
    tern_mode = 1'b1; sweep_mode = 1'b0; ptr_cfg = 2'd0;
    repeat (3) @(negedge clk);
    check("R1 reset valid", 32'(out_valid), 32'd0);
    check("R1 reset codes", 32'(cell_code), 32'd0);
    rst = 1'b0;
    model_reset();
    send(1, "R1 first use at cell 0");
    check("R1 cell0", 32'(cell_code), 32'h0001);
  endtask

  task automatic t_rotate();
    do_reset();
    tern_mode = 1'b1; sweep_mode = 1'b0; ptr_cfg = 2'd0;
    send(3, "R4 rotate");
    check("R4 cells 0-2", 32'(cell_code), 32'h0015);
    send(6, "R4 wrap");
    check("R4 cells 3-7,0", 32'(cell_code), 32'h5541);
    send(-5, "R4 negative");
    send(7, "R4 rotate");
    send(-8, "R4 full");
    check("R4 all minus", 32'(cell_code), 32'hFFFF);
  endtask

  task automatic t_sweep();
    do_reset();
    tern_mode = 1'b1; sweep_mode = 1'b1; ptr_cfg = 2'd0;
    send(2, "R5 fwd");
    check("R5 cells 0-1", 32'(cell_code), 32'h0005);
    send(3, "R5 back");
    check("R5 cells 7,0,1", 32'(cell_code), 32'h4005);
    send(1, "R5 fwd again");
    check("R5 cell 7", 32'(cell_code), 32'h4000);
    send(-4, "R5 back neg");
    send(5, "R5 fwd");
  endtask

  task automatic t_multi();
    do_reset();
    tern_mode = 1'b1; sweep_mode = 1'b0; ptr_cfg = 2'd1;
    send(2, "R6 p0");
    send(3, "R6 p1");
    check("R6 p1 from 0", 32'(cell_code), 32'h0015);
    send(1, "R6 p0");
    check("R6 p0 at 2", 32'(cell_code), 32'h0010);
    do_reset();
    ptr_cfg = 2'd2;
    for (int i = 0; i < 12; i++) send(((i * 5) % 17) - 8, "R6 four ptrs");
    do_reset();
    ptr_cfg = 2'd3; sweep_mode = 1'b1;
    for (int i = 0; i < 12; i++) send(((i * 7) % 17) - 8, "R6 four ptrs sweep");
  endtask

  task automatic t_zero();
    do_reset();
    tern_mode = 1'b1; sweep_mode = 1'b1; ptr_cfg = 2'd0;
    send(3, "R7 setup");
    send(0, "R7 zero");
    check("R7 all zero", 32'(cell_code), 32'h0000);
    send(2, "R7 direction kept");
    check("R7 back from 3", 32'(cell_code), 32'h0014);
  endtask

  task automatic t_binary();
    do_reset();
    tern_mode = 1'b0; sweep_mode = 1'b0; ptr_cfg = 2'd0;
    send(4, "R8 bin");
    send(-3, "R8 neg ignored");
    check("R8 neg zero", 32'(cell_code), 32'h0000);
    send(2, "R8 ptr unmoved");
    check("R8 cells 4-5", 32'(cell_code), 32'h0500);
  endtask

  task automatic t_sat();
    do_reset();
    tern_mode = 1'b1; sweep_mode = 1'b0; ptr_cfg = 2'd0;
    send(15, "R9 clamp pos");
    check("R9 all plus", 32'(cell_code), 32'h5555);
    send(-16, "R9 clamp neg");
    send(1, "R9 ptr back at 0");
    check("R9 cell0", 32'(cell_code), 32'h0001);
  endtask

  task automatic t_idle();
    logic [15:0] held;
    do_reset();
    tern_mode = 1'b1; sweep_mode = 1'b0; ptr_cfg = 2'd1;
    send(5, "R10 setup");
    held = cell_code;
    in_level = 5'sd7;
    repeat (4) @(negedge clk);
    check("R2 hold valid", 32'(out_valid), 32'd0);
    check("R2 hold codes", 32'(cell_code), 32'(held));
    send(2, "R10 turn unchanged");
    send(1, "R10 p0 at 5");
    check("R10 cell 5", 32'(cell_code), 32'h0400);
  endtask

  initial begin
    t_reset();
    t_rotate();
    t_sweep();
    t_multi();
    t_zero();
    t_binary();
    t_sat();
    t_idle();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule